// File: doc/BRIEF.md
# Multi-Mode Stepper Motor Sequencer

This block energizes the four coil phases (A, B, C, D) of a unipolar stepper motor. A controller gives it step pulses, a direction level, a drive-mode code and an enable. Each rising edge on the step input moves the motor by one step in the chosen direction. The block then drives a registered coil pattern for that position.

The step input may come from another clock domain. It passes through a two-flop synchronizer and an edge detector, which together produce a single-cycle strobe. A three-bit position counter holds the place in an eight-entry half-step cycle. The half-step mode moves this counter by one per step. Wave drive and full-step drive move it by two, and their decoder reads only the upper two bits. The mode can therefore change at any moment without losing the position. A combinational decoder turns the position and the mode into a coil pattern, and a register drives that pattern onto the coil outputs.

The mode, direction and enable inputs are assumed to be synchronous to the clock.

Top module: `stepseq_top`

## Requirements
- R1: While the active-low reset is low, the coil outputs are all zero from the first clock edge onward and the position returns to 0. After reset is released, the pattern for position 0 in the current mode appears: A only (0001) in every mode except full-step, where it is AB (0011).
- R2: With mode code 00 (wave), forward steps produce one coil at a time in the order A, B, C, D, then back to A. The coil bits are coil_o[0]=A, [1]=B, [2]=C, [3]=D, so the values are 0001, 0010, 0100, 1000.
- R3: With mode code 01 (full-step), forward steps produce two adjacent coils in the order AB, BC, CD, DA: 0011, 0110, 1100, 1001.
- R4: With mode code 10 (half-step), forward steps produce the eight-entry order A, AB, B, BC, C, CD, D, DA, with one and two coils alternating. In this mode each step moves the position by one.
- R5: dir_i high advances the sequence and dir_i low runs it in reverse. The position wraps modulo 8 in both directions.
- R6: Each rising edge of step_i advances the position exactly once, however long step_i stays high. Without an edge the position is held.
- R7: The new coil pattern appears on the fourth rising clock edge. The first of these four edges is the one that first samples step_i high.
- R8: A mode change keeps the position. The coil outputs show the new mode's pattern after the next clock edge.
- R9: With en_i low, the coil outputs go to zero at the next clock edge. Steps taken while disabled are still counted, and the correct pattern returns one edge after en_i goes high.
- R10: Mode code 11 behaves as wave drive.
- R11: Wave and full-step modes move the position by two half-steps, which leaves its lowest bit unchanged. Suppose a move into a four-state mode happens at an odd position. After N steps in that mode, a return to half-step shows the odd position plus or minus 2N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Coil enable; low forces all coils off |
| dir_i | input | 1 | 1 = forward, 0 = reverse |
| mode_i | input | 2 | 00 wave, 01 full-step, 10 half-step, 11 wave |
| step_i | input | 1 | Step request, may be asynchronous |
| coil_o | output | 4 | Coil enables, bit 0 = A through bit 3 = D |

## Verification
A step result has a fixed path: two synchronizer flops, the counter register, and then the coil register. The pattern is therefore due on the fourth edge after step_i is first sampled high. The bench checks this exactly by sampling on the falling edge after the third edge, where the old pattern must still show, and again after the fourth edge. Mode and enable changes pass only through the coil register, so they are checked on the falling edge right after the next rising edge. The sweeps step the bench far enough that every earlier change has settled before each comparison. Expected patterns are worked out arithmetically from a model position that the bench keeps itself.

// File: rtl/stepseq_pkg.sv
// Package: shared constants and the drive-mode encoding of the stepper sequencer.
// Assumes a four-phase motor; the half-step cycle is twice the phase count.
package stepseq_pkg;
    localparam int NUM_COILS   = 4;
    localparam int HALF_STATES = 2 * NUM_COILS;
    localparam int POS_BITS    = $clog2(HALF_STATES);
    localparam int SEL_BITS    = $clog2(NUM_COILS);

    typedef enum logic [1:0] {
        MODE_WAVE = 2'b00,
        MODE_FULL = 2'b01,
        MODE_HALF = 2'b10,
        MODE_RSVD = 2'b11
    } drive_mode_e;
endpackage

// File: rtl/stepseq_sync.sv
// Module: stepseq_sync
// Brings an asynchronous step level into the clock domain through STAGES flops,
// then emits a one-cycle strobe on its rising edge.
// Assumes STAGES >= 2. The strobe is combinational from the last two flops.
module stepseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic strobe_o
);
    logic [STAGES:0] chain_q;

    // Purpose: shift the input through the synchronizer and the edge-history flop.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    // Purpose: detect a rising edge on the synchronized level.
    always_comb begin
        strobe_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
endmodule

// File: rtl/stepseq_pos_counter.sv
// Module: stepseq_pos_counter
// Up/down position counter over the half-step cycle.
// Half-step mode moves by one; wave and full-step modes move by two, so the
// low bit is kept and the upper bits give the four-state position.
// Assumes the step strobe is one cycle wide and synchronous.
module stepseq_pos_counter
    import stepseq_pkg::*;
#(
    parameter int PBITS = POS_BITS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strobe_i,
    input  logic             dir_i,
    input  logic [1:0]       mode_i,
    output logic [PBITS-1:0] pos_o
);
    logic [PBITS-1:0] pos_q;
    logic [PBITS-1:0] stride;

    // Purpose: pick the stride for the current drive mode.
    always_comb begin
        if (drive_mode_e'(mode_i) == MODE_HALF) begin
            stride = PBITS'(1);
        end else begin
            stride = PBITS'(2);
        end
    end

    // Purpose: hold the position and move it by the stride on a strobe, with wraparound.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pos_q <= '0;
        end else if (strobe_i) begin
            if (dir_i) begin
                pos_q <= pos_q + stride;
            end else begin
                pos_q <= pos_q - stride;
            end
        end
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/stepseq_phase_decoder.sv
// Module: stepseq_phase_decoder
// Combinational map from the half-step position and the drive mode to a coil pattern.
// The upper position bits select the leading coil. Its neighbour, with wraparound,
// is also driven in full-step mode, and in half-step mode at odd positions.
// Assumes position width = SBITS + 1.
module stepseq_phase_decoder
    import stepseq_pkg::*;
#(
    parameter int COILS = NUM_COILS,
    parameter int SBITS = SEL_BITS
) (
    input  logic [SBITS:0]   pos_i,
    input  logic [1:0]       mode_i,
    output logic [COILS-1:0] coil_o
);
    logic [SBITS-1:0] lead;
    logic [SBITS-1:0] trail;
    logic             pair_on;

    // Purpose: choose the leading coil, its neighbour, and whether both are on.
    always_comb begin
        lead  = pos_i[SBITS:1];
        trail = lead + SBITS'(1);
        unique case (drive_mode_e'(mode_i))
            MODE_FULL: pair_on = 1'b1;
            MODE_HALF: pair_on = pos_i[0];
            default:   pair_on = 1'b0;
        endcase
    end

    // Purpose: expand the coil selection into one enable line per coil.
    always_comb begin
        for (int k = 0; k < COILS; k++) begin
            coil_o[k] = (SBITS'(k) == lead) || (pair_on && (SBITS'(k) == trail));
        end
    end
endmodule

// File: rtl/stepseq_top.sv
// Module: stepseq_top
// Multi-mode stepper sequencer: step synchronizer, shared position counter,
// mode-aware phase decoder and registered coil outputs.
// Assumes en_i, dir_i and mode_i are synchronous to clk_i; step_i may be asynchronous.
module stepseq_top
    import stepseq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       dir_i,
    input  logic [1:0] mode_i,
    input  logic       step_i,
    output logic [3:0] coil_o
);
    logic                 step_stb;
    logic [POS_BITS-1:0]  pos_q;
    logic [NUM_COILS-1:0] coil_next;
    logic [NUM_COILS-1:0] coil_q;

    stepseq_sync #(
        .STAGES (2)
    ) sync_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .async_i  (step_i),
        .strobe_o (step_stb)
    );

    stepseq_pos_counter #(
        .PBITS (POS_BITS)
    ) cnt_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (step_stb),
        .dir_i    (dir_i),
        .mode_i   (mode_i),
        .pos_o    (pos_q)
    );

    stepseq_phase_decoder #(
        .COILS (NUM_COILS),
        .SBITS (SEL_BITS)
    ) dec_i (
        .pos_i  (pos_q),
        .mode_i (mode_i),
        .coil_o (coil_next)
    );

    // Purpose: register the coil pattern, forced off in reset or when disabled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            coil_q <= '0;
        end else if (!en_i) begin
            coil_q <= '0;
        end else begin
            coil_q <= coil_next;
        end
    end

    assign coil_o = coil_q;
endmodule

// File: rtl/stepseq_checker.sv
// Module: stepseq_checker
// Temporal checks on the sequencer, attached by bind. Reads the step strobe and
// the position alongside the ports.
module stepseq_checker
    import stepseq_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic                en_i,
    input logic                dir_i,
    input logic [1:0]          mode_i,
    input logic [3:0]          coil_o,
    input logic                strobe,
    input logic [POS_BITS-1:0] pos
);
    assert_coils_off_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (coil_o == 4'b0000));

    assert_pos_held_no_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe |=> $stable(pos));

    assert_strobe_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe |=> !strobe);

    assert_wave_single_coil_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (mode_i == MODE_WAVE)) |=> ($countones(coil_o) == 1));

    assert_full_two_coils_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (mode_i == MODE_FULL)) |=> ($countones(coil_o) == 2));

    assert_half_fwd_stride_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe && dir_i && (mode_i == MODE_HALF)) |=> (pos == $past(pos) + POS_BITS'(1)));

    assert_quad_rev_stride_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe && !dir_i && (mode_i != MODE_HALF)) |=> (pos == $past(pos) - POS_BITS'(2)));
endmodule

bind stepseq_top stepseq_checker chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .dir_i  (dir_i),
    .mode_i (mode_i),
    .coil_o (coil_o),
    .strobe (step_stb),
    .pos    (pos_q)
);

// File: tb/stepseq_top_tb_top.sv
module stepseq_top_tb_top;
    logic       clk;
    logic       rst_n;
    logic       en;
    logic       dir;
    logic [1:0] mode;
    logic       step;
    logic [3:0] coil;

    int n_checks;
    int n_fail;
    int mpos;
    bit done;

    stepseq_top dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .en_i   (en),
        .dir_i  (dir),
        .mode_i (mode),
        .step_i (step),
        .coil_o (coil)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [3:0] expect_coil(int p, int m, bit e);
        int u;
        logic [3:0] r;
        if (!e) return 4'b0000;
        u = p / 2;
        r = 4'b0000;
        r[u] = 1'b1;
        if (m == 1 || (m == 2 && (p % 2) == 1)) r[(u + 1) % 4] = 1'b1;
        return r;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: coil actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_step();
        int amt;
        amt = (mode == 2'b10) ? 1 : 2;
        mpos = dir ? (mpos + amt) % 8 : (mpos + 8 - amt) % 8;
    endtask

    task automatic pulse_step();
        step = 1'b1;
        cycles(3);
        step = 1'b0;
        cycles(4);
        model_step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        done = 1'b0;
        n_checks = 0;
        n_fail = 0;
        rst_n = 1'b0;
        en = 1'b1;
        dir = 1'b1;
        mode = 2'b10;
        step = 1'b0;
        mpos = 0;
        cycles(3);
        check("R1 reset coils off", coil, 4'b0000);
        rst_n = 1'b1;
        cycles(2);
        check("R1 position 0 after reset", coil, expect_coil(0, 2, 1'b1));

        // R7: exact latency of one half-step forward
        step = 1'b1;
        cycles(3);
        check("R7 old pattern before 4th edge", coil, expect_coil(mpos, 2, 1'b1));
        cycles(1);
        model_step();
        check("R7 new pattern on 4th edge", coil, expect_coil(mpos, 2, 1'b1));
        // R6: holding step high gives no further advance
        cycles(20);
        check("R6 held step single advance", coil, expect_coil(mpos, 2, 1'b1));
        step = 1'b0;
        cycles(4);

        // R2 R3 R4 R5 R10: sweep every mode in both directions past wraparound
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                mode = 2'(m);
                dir = d[0];
                cycles(2);
                for (int s = 0; s < 9; s++) begin
                    pulse_step();
                    case (m)
                        0: check("R2 wave sequence R5 dir", coil, expect_coil(mpos, m, 1'b1));
                        1: check("R3 full sequence R5 dir", coil, expect_coil(mpos, m, 1'b1));
                        2: check("R4 half sequence R5 dir", coil, expect_coil(mpos, m, 1'b1));
                        default: check("R10 reserved as wave R5", coil, expect_coil(mpos, 0, 1'b1));
                    endcase
                end
            end
        end

        // R8 R11: go to an odd position in half-step, change modes, step, return
        mode = 2'b10;
        dir = 1'b1;
        cycles(2);
        if ((mpos % 2) == 0) pulse_step();
        check("R8 odd half position", coil, expect_coil(mpos, 2, 1'b1));
        mode = 2'b01;
        cycles(1);
        check("R8 mode change next edge full", coil, expect_coil(mpos, 1, 1'b1));
        mode = 2'b00;
        cycles(1);
        check("R8 mode change next edge wave", coil, expect_coil(mpos, 0, 1'b1));
        pulse_step();
        pulse_step();
        pulse_step();
        mode = 2'b10;
        cycles(1);
        check("R11 odd position kept by stride two", coil, expect_coil(mpos, 2, 1'b1));

        // R9: disable, step while off, re-enable
        mode = 2'b01;
        cycles(2);
        en = 1'b0;
        cycles(1);
        check("R9 disable next edge", coil, 4'b0000);
        dir = 1'b0;
        pulse_step();
        check("R9 steps while disabled coils off", coil, 4'b0000);
        en = 1'b1;
        cycles(1);
        check("R9 re-enable shows counted position", coil, expect_coil(mpos, 1, 1'b1));

        // R1: reset in mid-run returns to position 0
        mode = 2'b10;
        rst_n = 1'b0;
        cycles(1);
        check("R1 mid-run reset coils off", coil, 4'b0000);
        rst_n = 1'b1;
        mpos = 0;
        cycles(2);
        check("R1 mid-run reset position 0", coil, expect_coil(0, 2, 1'b1));
        mode = 2'b01;
        cycles(1);
        check("R1 full-step pattern at position 0", coil, 4'b0011);

        done = 1'b1;
        summary();
    end
endmodule